// File: doc/BRIEF.md
# Coprocessor Host Register Window

This block is the host side of a graphics coprocessor. It gives the host CPU a byte-wide window of 768 locations. Through it the host sees sixteen 16-bit general registers, a status word, a set of 8-bit control bytes, a cache base word and a 512-byte cache RAM. The host moves data with a 10-bit address, an 8-bit write bus, an 8-bit read bus and separate read and write strobes. Reads are combinational. Writes and read side effects take hold on the rising clock edge.

Toward the core, the block produces a one-cycle start pulse and a level that stays high while the core runs. It takes a stop pulse back from the core. A host write to the high byte of the program counter launches the core. When the core reports a stop, the running flag drops and an interrupt flag rises. The interrupt flag is cleared when the host reads the status high byte. A configuration bit can hide the interrupt from the host line.

Top module: `coproc_hostregs`

## Requirements
- R1: Each general register n (0 to 15) is reachable as two bytes: the low byte at offset 2n and the high byte at offset 2n+1. A written byte reads back unchanged, and the other byte is not disturbed.
- R2: A host write to offset 0x01F (program counter high byte) sets the running flag, status bit 5, on that clock edge. `core_start` is then high for exactly the following cycle. A write to offset 0x01E alone starts nothing.
- R3: A `core_stop` pulse clears the running flag and sets the interrupt flag, status bit 15, on the same edge. If a start write falls on that same edge, the core keeps running.
- R4: A host read of offset 0x031 returns the interrupt flag in bit 7 and clears the flag at the end of that read cycle. When `core_stop` arrives in the same cycle, the flag stays set.
- R5: `host_irq` is high exactly when the interrupt flag is set and configuration bit 7 (offset 0x037) is zero.
- R6: Offset 0x03B always reads the VERSION parameter (default 0x04), and host writes to it are ignored.
- R7: The cache base word at 0x03E/0x03F keeps address bits 15 to 4 as written. Bits 3 to 0 (offset 0x03E, bits 3:0) always read zero.
- R8: Offsets 0x100 to 0x2FF are a 512-byte cache RAM. Each byte reads back what was last written to it.
- R9: The unused offsets read zero and ignore writes. These are 0x020 to 0x02F, 0x032, 0x035, 0x03D, 0x040 to 0x0FF and 0x300 to 0x3FF.
- R10: The control bytes at 0x033, 0x034, 0x036, 0x037, 0x038, 0x039, 0x03A and 0x03C read back as written. Configuration bit 5 drives `cfg_fast_mul`.
- R11: Host writes to the status word change only the flag bits: low-byte mask 0x5E and high-byte mask 0x1F. The running flag and the interrupt flag cannot be written, and undefined status bits read zero.
- R12: After reset, all registers read zero except the version byte. `core_go`, `core_start` and `host_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 10 | Byte offset in the window |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe (read side effects) |
| host_wr | input | 1 | Write strobe |
| host_rdata | output | 8 | Read data for host_addr |
| core_start | output | 1 | One-cycle launch pulse to the core |
| core_go | output | 1 | Core running flag |
| core_stop | input | 1 | Stop pulse from the core |
| cfg_fast_mul | output | 1 | Multiplier speed select |
| host_irq | output | 1 | Interrupt request to host |

## Verification
A corrupted running or interrupt flag shows at `core_go`, at `host_irq` and in the status bytes the next time the host reads them. That is one cycle after the edge that caused it. A faulty address decode shows up as aliasing: a write to an unused or read-only offset is visible at the next read of that offset or of a real register. The bench reads both the target and its neighbours after every write. The read-clear ordering is caught on the second of two back-to-back status reads, one cycle after the first.

// File: rtl/coproc_hostregs.sv
module coproc_hostregs #(
  parameter logic [7:0] VERSION = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  input  logic       host_wr,
  output logic [7:0] host_rdata,
  output logic       core_start,
  output logic       core_go,
  input  logic       core_stop,
  output logic       cfg_fast_mul,
  output logic       host_irq
);
  localparam logic [7:0] SFR_LO_WMASK = 8'h5E;
  localparam logic [7:0] SFR_HI_WMASK = 8'h1F;

  logic [7:0]  gpr [32];
  logic [7:0]  cram [512];
  logic [15:0] sfr;
  logic [7:0]  bkram_en, prg_bank, rom_bank, cfg, scr_base, clk_sel, scr_mode, ram_bank;
  logic [11:0] cache_base;

  wire in_gpr  = host_addr[9:5] == 5'b00000;
  wire in_ctl  = host_addr[9:4] == 6'h03;
  wire in_cram = host_addr[9:8] == 2'b01 || host_addr[9:8] == 2'b10;
  wire [8:0] cram_idx = {host_addr[9], host_addr[7:0]};
  wire hit_start = host_wr && host_addr == 10'h01F;
  wire hit_irqrd = host_rd && host_addr == 10'h031;

  assign core_go      = sfr[5];
  assign cfg_fast_mul = cfg[5];
  assign host_irq     = sfr[15] & ~cfg[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) gpr[i] <= 8'h00;
      sfr <= 16'h0000;
      {bkram_en, prg_bank, rom_bank, cfg} <= '0;
      {scr_base, clk_sel, scr_mode, ram_bank} <= '0;
      cache_base <= '0;
      core_start <= 1'b0;
    end else begin
      core_start <= hit_start;
      if (host_wr && in_gpr) gpr[host_addr[4:0]] <= host_wdata;
      if (host_wr && in_ctl) begin
        case (host_addr[3:0])
          4'h0: sfr[7:0]  <= (sfr[7:0] & ~SFR_LO_WMASK) | (host_wdata & SFR_LO_WMASK);
          4'h1: sfr[15:8] <= (sfr[15:8] & ~SFR_HI_WMASK) | (host_wdata & SFR_HI_WMASK);
          4'h3: bkram_en <= host_wdata;
          4'h4: prg_bank <= host_wdata;
          4'h6: rom_bank <= host_wdata;
          4'h7: cfg      <= host_wdata;
          4'h8: scr_base <= host_wdata;
          4'h9: clk_sel  <= host_wdata;
          4'hA: scr_mode <= host_wdata;
          4'hC: ram_bank <= host_wdata;
          4'hE: cache_base[3:0]  <= host_wdata[7:4];
          4'hF: cache_base[11:4] <= host_wdata;
          default: ;
        endcase
      end
      if (hit_irqrd) sfr[15] <= 1'b0;
      if (core_stop) sfr[5]  <= 1'b0;
      if (hit_start) sfr[5]  <= 1'b1;
      if (core_stop) sfr[15] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr && in_cram) cram[cram_idx] <= host_wdata;
  end

  always_comb begin
    host_rdata = 8'h00;
    if (in_gpr) host_rdata = gpr[host_addr[4:0]];
    else if (in_cram) host_rdata = cram[cram_idx];
    else if (in_ctl) begin
      case (host_addr[3:0])
        4'h0: host_rdata = sfr[7:0];
        4'h1: host_rdata = sfr[15:8];
        4'h3: host_rdata = bkram_en;
        4'h4: host_rdata = prg_bank;
        4'h6: host_rdata = rom_bank;
        4'h7: host_rdata = cfg;
        4'h8: host_rdata = scr_base;
        4'h9: host_rdata = clk_sel;
        4'hA: host_rdata = scr_mode;
        4'hB: host_rdata = VERSION;
        4'hC: host_rdata = ram_bank;
        4'hE: host_rdata = {cache_base[3:0], 4'h0};
        4'hF: host_rdata = cache_base[11:4];
        default: host_rdata = 8'h00;
      endcase
    end
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> core_go); // R2
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop && !hit_start |=> !core_go && sfr[15]); // R3
  AST_GO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    core_go && !core_stop |=> core_go); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_irqrd && !core_stop |=> !sfr[15]); // R4
  AST_CBR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 10'h03E |-> host_rdata[3:0] == 4'h0); // R7
  AST_TOP_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr[9:8] == 2'b11 |-> host_rdata == 8'h00); // R9
endmodule

// File: tb/coproc_hostregs_test.sv
module coproc_hostregs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic       core_stop = 1'b0;
  logic [7:0] host_rdata;
  logic       core_start, core_go, cfg_fast_mul, host_irq;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  coproc_hostregs uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .core_start(core_start), .core_go(core_go), .core_stop(core_stop),
    .cfg_fast_mul(cfg_fast_mul), .host_irq(host_irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (host_rd) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (host_rdata !== e) begin
        failures++;
        $display("FAIL %s read addr=%h actual=%h expected=%h", t, host_addr, host_rdata, e);
      end
    end
  end

  task automatic check(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #2;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] e, input string t, input logic stop = 1'b0);
    @(posedge clk); #2;
    exp_q.push_back(e); tag_q.push_back(t);
    host_addr = a; host_rd = 1'b1; core_stop = stop;
    @(posedge clk); #2;
    host_rd = 1'b0; core_stop = 1'b0;
  endtask

  task automatic stop_pulse();
    @(posedge clk); #2;
    core_stop = 1'b1;
    @(posedge clk); #2;
    core_stop = 1'b0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R12 reset state
    check("R12 core_go", core_go, 1'b0);
    check("R12 core_start", core_start, 1'b0);
    check("R12 host_irq", host_irq, 1'b0);
    rd(10'h030, 8'h00, "R12");
    rd(10'h031, 8'h00, "R12");
    rd(10'h03B, 8'h04, "R12");
    rd(10'h00A, 8'h00, "R12");
    // R1 byte lanes
    wr(10'h004, 8'h34); wr(10'h005, 8'h12);
    wr(10'h01C, 8'hAA);
    rd(10'h004, 8'h34, "R1"); rd(10'h005, 8'h12, "R1");
    rd(10'h01C, 8'hAA, "R1"); rd(10'h01D, 8'h00, "R1");
    wr(10'h01D, 8'h55);
    rd(10'h01C, 8'hAA, "R1"); rd(10'h01D, 8'h55, "R1");
    // R9 unused offsets
    wr(10'h020, 8'hFF); wr(10'h032, 8'hFF); wr(10'h035, 8'hFF);
    wr(10'h03D, 8'hFF); wr(10'h0F0, 8'hFF); wr(10'h3F0, 8'hFF);
    rd(10'h020, 8'h00, "R9"); rd(10'h032, 8'h00, "R9"); rd(10'h035, 8'h00, "R9");
    rd(10'h03D, 8'h00, "R9"); rd(10'h0F0, 8'h00, "R9"); rd(10'h3F0, 8'h00, "R9");
    rd(10'h000, 8'h00, "R9"); rd(10'h010, 8'h00, "R9");
    // R6 version read-only
    wr(10'h03B, 8'hFF);
    rd(10'h03B, 8'h04, "R6");
    // R7 cache base
    wr(10'h03E, 8'hFF); wr(10'h03F, 8'hA5);
    rd(10'h03E, 8'hF0, "R7"); rd(10'h03F, 8'hA5, "R7");
    // R10 control bytes
    wr(10'h037, 8'h20);
    check("R10 cfg_fast_mul", cfg_fast_mul, 1'b1);
    wr(10'h034, 8'h7E); wr(10'h03A, 8'h3F); wr(10'h03C, 8'h03); wr(10'h033, 8'h01);
    rd(10'h034, 8'h7E, "R10"); rd(10'h03A, 8'h3F, "R10");
    rd(10'h03C, 8'h03, "R10"); rd(10'h033, 8'h01, "R10"); rd(10'h037, 8'h20, "R10");
    // R11 status masking
    wr(10'h030, 8'hFF); wr(10'h031, 8'hFF);
    rd(10'h030, 8'h5E, "R11"); rd(10'h031, 8'h1F, "R11");
    check("R11 core_go", core_go, 1'b0);
    check("R11 host_irq", host_irq, 1'b0);
    wr(10'h030, 8'h00); wr(10'h031, 8'h00);
    rd(10'h030, 8'h00, "R11"); rd(10'h031, 8'h00, "R11");
    // R2 start
    wr(10'h01E, 8'h00);
    check("R2 no start on low byte", core_start, 1'b0);
    check("R2 no go on low byte", core_go, 1'b0);
    wr(10'h01F, 8'h80);
    check("R2 start pulse", core_start, 1'b1);
    check("R2 go set", core_go, 1'b1);
    @(posedge clk); #2;
    check("R2 start one cycle", core_start, 1'b0);
    rd(10'h030, 8'h20, "R2"); rd(10'h01F, 8'h80, "R2");
    // R3 stop, R5 irq out, R4 read clear
    stop_pulse();
    check("R3 go cleared", core_go, 1'b0);
    check("R5 irq out", host_irq, 1'b1);
    rd(10'h031, 8'h80, "R3");
    check("R4 irq out cleared", host_irq, 1'b0);
    rd(10'h031, 8'h00, "R4");
    // R5 mask
    wr(10'h037, 8'hA0);
    wr(10'h01F, 8'h80); stop_pulse();
    check("R5 masked", host_irq, 1'b0);
    wr(10'h037, 8'h20);
    check("R5 unmasked", host_irq, 1'b1);
    // R4 coincident set wins
    rd(10'h031, 8'h80, "R4", 1'b1);
    rd(10'h031, 8'h80, "R4");
    rd(10'h031, 8'h00, "R4");
    // R3 start and stop on same edge
    @(posedge clk); #2;
    host_addr = 10'h01F; host_wdata = 8'h00; host_wr = 1'b1; core_stop = 1'b1;
    @(posedge clk); #2;
    host_wr = 1'b0; core_stop = 1'b0;
    check("R3 start wins", core_go, 1'b1);
    rd(10'h031, 8'h80, "R3");
    stop_pulse();
    rd(10'h031, 8'h80, "R3");
    // R8 cache RAM
    wr(10'h100, 8'h11); wr(10'h1FF, 8'h22); wr(10'h200, 8'h33); wr(10'h2FF, 8'h44);
    rd(10'h100, 8'h11, "R8"); rd(10'h1FF, 8'h22, "R8");
    rd(10'h200, 8'h33, "R8"); rd(10'h2FF, 8'h44, "R8");
    rd(10'h000, 8'h00, "R8"); rd(10'h3FF, 8'h00, "R9");
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard left %0d items", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule